// File: doc/BRIEF.md
# Operand Cache Array Access Port

This block gives software direct word access to the storage of a direct-mapped operand cache, bypassing normal cached loads and stores. Two address windows are offered. In the tag window, each access picks one cache entry from its address and either returns that entry's tag together with its valid and dirty flags packed into a single word, or overwrites the tag and both flags. In the data window, each access reads or writes one 32-bit word of the line storage without touching any flag.

A tag write that lands on an entry holding a valid, dirty line first pushes the whole line out to external memory as an eight-beat burst to the line's old address, and only then installs the new tag and flags. The request port holds its ready low for the length of that burst. Tag writes with the associative-mode address bit set are accepted and have no effect. All accesses are 32 bits wide. Reads return data one cycle after they are accepted.

Top module: `ocache_array_port`

## Requirements
- R1: After synchronous reset every entry reads back as all zeros from the tag window (tag 0, valid 0, dirty 0), `req_ready` is 1, and `wb_valid` and `rsp_valid` are 0.
- R2: A tag-window read of the entry selected by address bits 13:5 returns the stored tag in bits 28:10, the dirty flag in bit 1 and the valid flag in bit 0; bits 31:29 and 9:2 read as zero.
- R3: A tag-window write with address bit 3 set is accepted, starts no burst, keeps `req_ready` high and leaves the entry's tag and flags unchanged.
- R4: A tag-window write with address bit 3 clear, to an entry that is both valid and dirty, first sends eight beats on the write-back port: `wb_addr` is the old line address (stored tag in bits 28:10, entry index bits 4:0 in bits 9:5, bits 4:0 zero), `wb_beat` counts 0 to 7, `wb_data` is data word `wb_beat` of that line, and `wb_last` is 1 only on beat 7. The entry keeps its old contents until the last beat is accepted.
- R5: A tag-window write with address bit 3 clear installs write-data bits 28:10 as the tag, write-data bit 0 as valid and bit 1 as dirty; if the entry was not both valid and dirty, no burst starts and `req_ready` stays 1.
- R6: A data-window access reads or writes the 32-bit word selected by address bits 13:2 (bits 13:5 entry, bits 4:2 word within the line) and changes no tag or flag.
- R7: From the cycle after an evicting tag write is accepted until the cycle after its last beat is accepted, `req_ready` is 0 and no request is taken.
- R8: Every accepted read gives `rsp_valid` for exactly one cycle, the cycle after acceptance; writes give no response; a read accepted in the cycle right after a non-evicting tag write to the same entry returns the newly written value.
- R9: While `wb_valid` is 1 and `wb_ready` is 0, `wb_addr`, `wb_beat` and `wb_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data_win | input | 1 | 1 = data window, 0 = tag window |
| req_addr | input | 12 | Access address bits 13:2 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| wb_valid | output | 1 | Write-back beat present |
| wb_ready | input | 1 | External memory takes the beat |
| wb_addr | output | 29 | Byte address of the line being written back |
| wb_beat | output | 3 | Word index of the current beat |
| wb_data | output | 32 | Beat data |
| wb_last | output | 1 | Final beat of the burst |

## Verification
The hardest situation to reach is an eviction: the target entry must already hold a line that is both valid and dirty, which only an earlier tag write with both flag bits set can arrange, and the burst must then meet back-pressure while another request waits at the port. The random phase confines indices to six entries whose lines are filled first, so random tag writes with random flag bits keep landing on dirty lines; every burst is driven with a random stall rate on `wb_ready`, and a data write is held on the request port throughout the burst so that a wrongly taken request would corrupt the model's view of the data. Directed cases cover the packed read format, associative writes and a read issued in the cycle right after a tag write.

// File: rtl/oca_pkg.sv
// Shared definitions for the operand cache array access port.
package oca_pkg;
    localparam int OCA_DATA_W = 32;

    typedef enum logic [1:0] {
        EV_IDLE = 2'd0,
        EV_LOAD = 2'd1,
        EV_SEND = 2'd2
    } evict_state_t;
endpackage

// File: rtl/oca_tag_store.sv
// Tag and flag storage, one entry per cache line.
// Assumes: at most one write per cycle; read is combinational on rd_idx.
// Tags and flags clear on reset so a fresh entry reads as all zeros.
module oca_tag_store #(
    parameter int ENTRY_BITS = 9,
    parameter int TAG_W      = 19
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ENTRY_BITS-1:0] rd_idx,
    output logic [TAG_W-1:0]      rd_tag,
    output logic                  rd_valid,
    output logic                  rd_dirty,
    input  logic                  we,
    input  logic [ENTRY_BITS-1:0] wr_idx,
    input  logic [TAG_W-1:0]      wr_tag,
    input  logic                  wr_valid,
    input  logic                  wr_dirty
);
    localparam int ENTRIES = 1 << ENTRY_BITS;

    logic [TAG_W-1:0] tag_q   [ENTRIES];
    logic             valid_q [ENTRIES];
    logic             dirty_q [ENTRIES];

    // Store a new tag and both flags, or clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]   <= '0;
                valid_q[i] <= 1'b0;
                dirty_q[i] <= 1'b0;
            end
        end else if (we) begin
            tag_q[wr_idx]   <= wr_tag;
            valid_q[wr_idx] <= wr_valid;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    // Look up the addressed entry.
    always_comb begin
        rd_tag   = tag_q[rd_idx];
        rd_valid = valid_q[rd_idx];
        rd_dirty = dirty_q[rd_idx];
    end

    // R5
    flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (tag_q[$past(wr_idx)] == $past(wr_tag))
            && (valid_q[$past(wr_idx)] == $past(wr_valid))
            && (dirty_q[$past(wr_idx)] == $past(wr_dirty)));
endmodule

// File: rtl/oca_data_store.sv
// Line data storage as a flat array of 32-bit words.
// Assumes: index = {entry, word-in-line}; one synchronous read and one
// write port; read data appears the cycle after rd_en and then holds.
module oca_data_store #(
    parameter int WIDX_W = 12
) (
    input  logic                         clk,
    input  logic                         rd_en,
    input  logic [WIDX_W-1:0]            rd_idx,
    output logic [oca_pkg::OCA_DATA_W-1:0] rd_q,
    input  logic                         we,
    input  logic [WIDX_W-1:0]            wr_idx,
    input  logic [oca_pkg::OCA_DATA_W-1:0] wr_data
);
    localparam int WORDS = 1 << WIDX_W;

    logic [oca_pkg::OCA_DATA_W-1:0] mem [WORDS];

    // Write one word.
    always_ff @(posedge clk) begin
        if (we) mem[wr_idx] <= wr_data;
    end

    // Registered read, held while rd_en is low.
    always_ff @(posedge clk) begin
        if (rd_en) rd_q <= mem[rd_idx];
    end
endmodule

// File: rtl/oca_evict_ctrl.sv
// Dirty-line eviction sequencer.
// On start it latches the entry, its old tag and the pending new tag and
// flags, streams the old line out one word per beat (a load cycle then a
// send cycle per word), and on the last accepted beat issues the deferred
// tag-store update. Assumes start is only raised while busy is low.
module oca_evict_ctrl
    import oca_pkg::*;
#(
    parameter int ENTRY_BITS     = 9,
    parameter int LINE_WORD_BITS = 3,
    parameter int TAG_W          = 19,
    parameter int KEEP_W         = 5,
    parameter int PADDR_W        = 29
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic [ENTRY_BITS-1:0]                start_idx,
    input  logic [TAG_W-1:0]                     start_old_tag,
    input  logic [TAG_W-1:0]                     start_new_tag,
    input  logic                                 start_new_valid,
    input  logic                                 start_new_dirty,
    input  logic [OCA_DATA_W-1:0]                rd_q,
    input  logic                                 wb_ready,
    output logic                                 busy,
    output logic                                 rd_en,
    output logic [ENTRY_BITS+LINE_WORD_BITS-1:0] rd_widx,
    output logic                                 commit,
    output logic [ENTRY_BITS-1:0]                commit_idx,
    output logic [TAG_W-1:0]                     commit_tag,
    output logic                                 commit_valid,
    output logic                                 commit_dirty,
    output logic                                 wb_valid,
    output logic [PADDR_W-1:0]                   wb_addr,
    output logic [LINE_WORD_BITS-1:0]            wb_beat,
    output logic [OCA_DATA_W-1:0]                wb_data,
    output logic                                 wb_last
);
    localparam int LINE_LSB = LINE_WORD_BITS + 2;
    localparam logic [LINE_WORD_BITS-1:0] LAST_BEAT = '1;

    evict_state_t              state_q;
    logic [LINE_WORD_BITS-1:0] beat_q;
    logic [ENTRY_BITS-1:0]     idx_q;
    logic [TAG_W-1:0]          old_tag_q;
    logic [TAG_W-1:0]          new_tag_q;
    logic                      new_valid_q;
    logic                      new_dirty_q;

    // Latch the eviction context when a burst starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q       <= '0;
            old_tag_q   <= '0;
            new_tag_q   <= '0;
            new_valid_q <= 1'b0;
            new_dirty_q <= 1'b0;
        end else if (start && state_q == EV_IDLE) begin
            idx_q       <= start_idx;
            old_tag_q   <= start_old_tag;
            new_tag_q   <= start_new_tag;
            new_valid_q <= start_new_valid;
            new_dirty_q <= start_new_dirty;
        end
    end

    // Walk load/send per word until the last beat is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EV_IDLE;
            beat_q  <= '0;
        end else begin
            unique case (state_q)
                EV_IDLE: begin
                    beat_q <= '0;
                    if (start) state_q <= EV_LOAD;
                end
                EV_LOAD: state_q <= EV_SEND;
                EV_SEND: begin
                    if (wb_ready) begin
                        if (beat_q == LAST_BEAT) begin
                            state_q <= EV_IDLE;
                        end else begin
                            beat_q  <= beat_q + 1'b1;
                            state_q <= EV_LOAD;
                        end
                    end
                end
                default: state_q <= EV_IDLE;
            endcase
        end
    end

    // Drive the word fetch, the burst port and the deferred update.
    always_comb begin
        busy         = (state_q != EV_IDLE);
        rd_en        = (state_q == EV_LOAD);
        rd_widx      = {idx_q, beat_q};
        wb_valid     = (state_q == EV_SEND);
        wb_beat      = beat_q;
        wb_last      = (beat_q == LAST_BEAT);
        wb_data      = rd_q;
        wb_addr      = {old_tag_q, idx_q[KEEP_W-1:0], {LINE_LSB{1'b0}}};
        commit       = wb_valid && wb_ready && wb_last;
        commit_idx   = idx_q;
        commit_tag   = new_tag_q;
        commit_valid = new_valid_q;
        commit_dirty = new_dirty_q;
    end

    // R9
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_beat)
                                  && $stable(wb_addr) && $stable(wb_data));

    // R4
    beat_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && wb_ready && !wb_last |=> !wb_valid && busy
                                             && (wb_beat == $past(wb_beat) + 1'b1));
endmodule

// File: rtl/ocache_array_port.sv
// Direct access port into the operand cache tag and data arrays.
// Decodes the entry (and word) from the access address, packs tag and
// flags into a read word, defers a tag write behind a write-back burst
// when the old line is valid and dirty, and ignores associative tag
// writes. Assumes 32-bit accesses only; reads answer one cycle later.
module ocache_array_port
    import oca_pkg::*;
#(
    parameter int ENTRY_BITS     = 9,
    parameter int LINE_WORD_BITS = 3,
    parameter int TAG_LSB        = 10,
    parameter int PADDR_W        = 29,
    parameter int ASSOC_BIT      = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_valid,
    output logic                                 req_ready,
    input  logic                                 req_write,
    input  logic                                 req_data_win,
    input  logic [ENTRY_BITS+LINE_WORD_BITS+1:2] req_addr,
    input  logic [OCA_DATA_W-1:0]                req_wdata,
    output logic                                 rsp_valid,
    output logic [OCA_DATA_W-1:0]                rsp_rdata,
    output logic                                 wb_valid,
    input  logic                                 wb_ready,
    output logic [PADDR_W-1:0]                   wb_addr,
    output logic [LINE_WORD_BITS-1:0]            wb_beat,
    output logic [OCA_DATA_W-1:0]                wb_data,
    output logic                                 wb_last
);
    localparam int LINE_LSB = LINE_WORD_BITS + 2;
    localparam int ADDR_W   = ENTRY_BITS + LINE_LSB;
    localparam int WIDX_W   = ENTRY_BITS + LINE_WORD_BITS;
    localparam int TAG_W    = PADDR_W - TAG_LSB;
    localparam int KEEP_W   = TAG_LSB - LINE_LSB;
    localparam int HI_PAD   = OCA_DATA_W - PADDR_W;
    localparam int MID_PAD  = TAG_LSB - 2;

    // Request decode
    logic                  accept;
    logic [ENTRY_BITS-1:0] entry;
    logic [WIDX_W-1:0]     widx;
    logic                  assoc;
    logic                  tag_wr;
    logic                  need_wb;
    logic [TAG_W-1:0]      new_tag;
    logic                  unused_wdata;

    // Tag store hookup
    logic [TAG_W-1:0]      old_tag;
    logic                  old_valid;
    logic                  old_dirty;
    logic                  ts_we;
    logic [ENTRY_BITS-1:0] ts_idx;
    logic [TAG_W-1:0]      ts_tag;
    logic                  ts_valid;
    logic                  ts_dirty;

    // Data store hookup
    logic                  ds_rd_en;
    logic [WIDX_W-1:0]     ds_rd_idx;
    logic [OCA_DATA_W-1:0] ds_q;
    logic                  ds_we;

    // Eviction sequencer hookup
    logic                  ev_busy;
    logic                  ev_rd_en;
    logic [WIDX_W-1:0]     ev_rd_widx;
    logic                  ev_commit;
    logic [ENTRY_BITS-1:0] ev_idx;
    logic [TAG_W-1:0]      ev_tag;
    logic                  ev_valid;
    logic                  ev_dirty;

    // Response registers
    logic                  rsp_valid_q;
    logic                  rsp_win_q;
    logic [OCA_DATA_W-1:0] tag_word_q;

    // Decode the request and decide whether a tag write must evict first.
    always_comb begin
        req_ready = !ev_busy;
        accept    = req_valid && req_ready;
        entry     = req_addr[ADDR_W-1:LINE_LSB];
        widx      = req_addr[ADDR_W-1:2];
        assoc     = req_addr[ASSOC_BIT];
        new_tag   = req_wdata[PADDR_W-1:TAG_LSB];
        tag_wr    = accept && req_write && !req_data_win && !assoc;
        need_wb   = tag_wr && old_valid && old_dirty;
    end

    // Bits of the write word that the tag window drops.
    assign unused_wdata = ^{req_wdata[OCA_DATA_W-1:PADDR_W], req_wdata[TAG_LSB-1:2]};

    // Pick the tag-store writer: deferred eviction update or direct write.
    always_comb begin
        if (ev_commit) begin
            ts_we    = 1'b1;
            ts_idx   = ev_idx;
            ts_tag   = ev_tag;
            ts_valid = ev_valid;
            ts_dirty = ev_dirty;
        end else begin
            ts_we    = tag_wr && !need_wb;
            ts_idx   = entry;
            ts_tag   = new_tag;
            ts_valid = req_wdata[0];
            ts_dirty = req_wdata[1];
        end
    end

    // Share the data-store read port between reads and the burst.
    always_comb begin
        ds_we = accept && req_write && req_data_win;
        if (ev_busy) begin
            ds_rd_en  = ev_rd_en;
            ds_rd_idx = ev_rd_widx;
        end else begin
            ds_rd_en  = accept && !req_write && req_data_win;
            ds_rd_idx = widx;
        end
    end

    oca_tag_store #(
        .ENTRY_BITS (ENTRY_BITS),
        .TAG_W      (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (entry),
        .rd_tag   (old_tag),
        .rd_valid (old_valid),
        .rd_dirty (old_dirty),
        .we       (ts_we),
        .wr_idx   (ts_idx),
        .wr_tag   (ts_tag),
        .wr_valid (ts_valid),
        .wr_dirty (ts_dirty)
    );

    oca_data_store #(
        .WIDX_W (WIDX_W)
    ) u_data (
        .clk     (clk),
        .rd_en   (ds_rd_en),
        .rd_idx  (ds_rd_idx),
        .rd_q    (ds_q),
        .we      (ds_we),
        .wr_idx  (widx),
        .wr_data (req_wdata)
    );

    oca_evict_ctrl #(
        .ENTRY_BITS     (ENTRY_BITS),
        .LINE_WORD_BITS (LINE_WORD_BITS),
        .TAG_W          (TAG_W),
        .KEEP_W         (KEEP_W),
        .PADDR_W        (PADDR_W)
    ) u_evict (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (need_wb),
        .start_idx       (entry),
        .start_old_tag   (old_tag),
        .start_new_tag   (new_tag),
        .start_new_valid (req_wdata[0]),
        .start_new_dirty (req_wdata[1]),
        .rd_q            (ds_q),
        .wb_ready        (wb_ready),
        .busy            (ev_busy),
        .rd_en           (ev_rd_en),
        .rd_widx         (ev_rd_widx),
        .commit          (ev_commit),
        .commit_idx      (ev_idx),
        .commit_tag      (ev_tag),
        .commit_valid    (ev_valid),
        .commit_dirty    (ev_dirty),
        .wb_valid        (wb_valid),
        .wb_addr         (wb_addr),
        .wb_beat         (wb_beat),
        .wb_data         (wb_data),
        .wb_last         (wb_last)
    );

    // Capture read responses: packed tag word now, data word from the store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_win_q   <= 1'b0;
            tag_word_q  <= '0;
        end else begin
            rsp_valid_q <= accept && !req_write;
            if (accept && !req_write) begin
                rsp_win_q  <= req_data_win;
                tag_word_q <= {{HI_PAD{1'b0}}, old_tag, {MID_PAD{1'b0}}, old_dirty, old_valid};
            end
        end
    end

    // Select the response source.
    always_comb begin
        rsp_valid = rsp_valid_q;
        rsp_rdata = rsp_win_q ? ds_q : tag_word_q;
    end

    // R3
    assoc_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_write && !req_data_win && assoc |=> req_ready && !wb_valid);

    // R6
    data_write_no_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_write && req_data_win |=> req_ready && !wb_valid);

    // R4
    evict_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_write && !req_data_win && !assoc && old_valid && old_dirty
        |=> !req_ready);

    // R5
    clean_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_write && !req_data_win && !(old_valid && old_dirty)
        |=> req_ready);

    // R8
    read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !req_write |=> rsp_valid);

    // R8
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && !req_write) |=> !rsp_valid);

    // R7
    wb_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !req_ready);
endmodule

// File: tb/tb_ocache_array_port.sv
`timescale 1ns/1ps
module tb_ocache_array_port;
    localparam int NE = 512;
    localparam int NW = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_data_win = 1'b0;
    logic [13:2] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        wb_valid;
    logic        wb_ready = 1'b0;
    logic [28:0] wb_addr;
    logic [2:0]  wb_beat;
    logic [31:0] wb_data;
    logic        wb_last;

    always #2 clk = ~clk;

    ocache_array_port dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_data_win(req_data_win), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
        .wb_beat(wb_beat), .wb_data(wb_data), .wb_last(wb_last)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [18:0] m_tag [NE];
    bit          m_v   [NE];
    bit          m_d   [NE];
    logic [31:0] m_data[NW];
    int          pool  [6] = '{0, 1, 5, 200, 510, 511};

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] tag_word(input int idx);
        return {3'b000, m_tag[idx], 8'h00, m_d[idx], m_v[idx]};
    endfunction

    function automatic logic [13:2] mk_addr(input int idx, input int w);
        return {idx[8:0], w[2:0]};
    endfunction

    // Present one request at a negedge; return at the negedge after acceptance.
    task automatic issue(input bit wr, input bit dwin, input logic [13:2] a, input logic [31:0] wd);
        req_valid = 1'b1; req_write = wr; req_data_win = dwin; req_addr = a; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic rd_chk(input bit dwin, input logic [13:2] a, input logic [31:0] exp, input string rq);
        issue(1'b0, dwin, a, 32'h0);
        check(rsp_valid === 1'b1, {rq, " rsp_valid"}, {31'b0, rsp_valid}, 32'h1);
        check(rsp_rdata === exp, rq, rsp_rdata, exp);
    endtask

    task automatic wr_data(input int idx, input int w, input logic [31:0] wd);
        issue(1'b1, 1'b1, mk_addr(idx, w), wd);
        m_data[{idx[8:0], w[2:0]}] = wd;
    endtask

    // Tag write with model update and, when due, a checked eviction burst.
    task automatic wr_tag(input int idx, input bit asc, input logic [31:0] wd, input int stall);
        bit evict;
        logic [28:0] exp_addr;
        int b;
        int guard;
        evict = !asc && m_v[idx] && m_d[idx];
        exp_addr = {m_tag[idx], idx[4:0], 5'b00000};
        issue(1'b1, 1'b0, {idx[8:0], 1'b0, asc, 1'b0}, wd);
        if (asc) begin
            // R3: accepted, no burst, ready stays high
            check(req_ready === 1'b1 && wb_valid === 1'b0, "R3 assoc write inert",
                  {30'b0, req_ready, wb_valid}, 32'h2);
            return;
        end
        if (!evict) begin
            // R5: no burst for a clean or invalid entry
            check(req_ready === 1'b1 && wb_valid === 1'b0, "R5 no eviction",
                  {30'b0, req_ready, wb_valid}, 32'h2);
        end else begin
            // R7: ready drops right after acceptance
            check(req_ready === 1'b0, "R7 ready low in burst", {31'b0, req_ready}, 32'h0);
            b = 0;
            guard = 0;
            // hold a junk data write on the port; it must not be taken
            req_valid = 1'b1; req_write = 1'b1; req_data_win = 1'b1;
            req_addr = mk_addr(idx, 0); req_wdata = 32'hDEAD_0000 ^ idx;
            while (b < 8 && guard < 2000) begin
                guard++;
                wb_ready = ($urandom % 100) >= stall;
                if (wb_valid) begin
                    check(wb_beat === b[2:0], "R4 beat index", {29'b0, wb_beat}, b);
                    check(wb_addr === exp_addr, "R4 old line address", {3'b0, wb_addr}, {3'b0, exp_addr});
                    check(wb_data === m_data[{idx[8:0], b[2:0]}], "R4/R9 beat data",
                          wb_data, m_data[{idx[8:0], b[2:0]}]);
                    check(wb_last === (b == 7), "R4 last flag", {31'b0, wb_last}, {31'b0, (b == 7)});
                end
                check(req_ready === 1'b0, "R7 ready low in burst", {31'b0, req_ready}, 32'h0);
                @(posedge clk);
                if (wb_valid && wb_ready) b++;
                @(negedge clk);
            end
            req_valid = 1'b0;
            wb_ready = 1'b0;
            if (guard >= 2000) check(1'b0, "R4 burst hung", b, 8);
            check(req_ready === 1'b1 && wb_valid === 1'b0, "R7 ready back after burst",
                  {30'b0, req_ready, wb_valid}, 32'h2);
        end
        m_tag[idx] = wd[28:10];
        m_v[idx] = wd[0];
        m_d[idx] = wd[1];
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] wd;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NE; i++) begin m_tag[i] = '0; m_v[i] = 1'b0; m_d[i] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(req_ready === 1'b1, "R1 ready after reset", {31'b0, req_ready}, 32'h1);
        check(wb_valid === 1'b0 && rsp_valid === 1'b0, "R1 idle outputs",
              {30'b0, wb_valid, rsp_valid}, 32'h0);
        rd_chk(1'b0, mk_addr(0, 0), 32'h0, "R1 entry 0 clear");
        rd_chk(1'b0, mk_addr(511, 0), 32'h0, "R1 entry 511 clear");
        rd_chk(1'b0, mk_addr(300, 0), 32'h0, "R1 entry 300 clear");
        @(negedge clk);
        check(rsp_valid === 1'b0, "R8 response lasts one cycle", {31'b0, rsp_valid}, 32'h0);

        // R6: fill all pool lines through the data window, read some back
        for (int p = 0; p < 6; p++)
            for (int w = 0; w < 8; w++)
                wr_data(pool[p], w, $urandom);
        check(rsp_valid === 1'b0, "R8 write gives no response", {31'b0, rsp_valid}, 32'h0);
        for (int w = 0; w < 8; w++)
            rd_chk(1'b1, mk_addr(5, w), m_data[{9'd5, w[2:0]}], "R6 data word readback");
        rd_chk(1'b0, mk_addr(5, 0), tag_word(5), "R6 data writes leave flags");

        // R5 / R2: install a dirty tag with junk in dropped bits
        wd = 32'hE000_03FC | (32'h12345 << 10) | 32'h3;
        wr_tag(5, 1'b0, wd, 0);
        rd_chk(1'b0, mk_addr(5, 0), {3'b0, wd[28:10], 8'h00, 2'b11}, "R2 packed tag word");

        // R3: associative write changes nothing
        wr_tag(5, 1'b1, 32'h0ABC_DC00, 0);
        rd_chk(1'b0, mk_addr(5, 0), tag_word(5), "R3 entry unchanged");

        // R4 / R7 / R9: evict the dirty line under heavy stall
        wr_tag(5, 1'b0, 32'h0555_5401, 60);
        rd_chk(1'b0, mk_addr(5, 0), tag_word(5), "R5 tag after eviction");
        rd_chk(1'b1, mk_addr(5, 0), m_data[{9'd5, 3'd0}], "R7 junk write not taken");

        // R6: data write on a valid line keeps flags
        wr_tag(1, 1'b0, 32'h1FFF_FC03, 0);
        wr_data(1, 3, 32'hCAFE_F00D);
        rd_chk(1'b0, mk_addr(1, 0), tag_word(1), "R6 flags kept after data write");

        // R8: read in the cycle right after a tag write to the same entry
        req_valid = 1'b1; req_write = 1'b1; req_data_win = 1'b0;
        req_addr = mk_addr(300, 0); req_wdata = 32'h0F0F_0C02;
        @(posedge clk);
        @(negedge clk);
        m_tag[300] = req_wdata[28:10]; m_v[300] = 1'b0; m_d[300] = 1'b1;
        req_write = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b1 && rsp_rdata === tag_word(300), "R8 back-to-back read",
              rsp_rdata, tag_word(300));

        // Random mix over a small set of entries
        for (int n = 0; n < 500; n++) begin
            int idx;
            int op;
            idx = pool[$urandom % 6];
            op = $urandom % 4;
            case (op)
                0: wr_data(idx, $urandom % 8, $urandom);
                1: begin
                    int w;
                    w = $urandom % 8;
                    rd_chk(1'b1, mk_addr(idx, w), m_data[{idx[8:0], w[2:0]}], "R6 random data read");
                end
                2: wr_tag(idx, ($urandom % 5) == 0, $urandom, $urandom % 70);
                default: rd_chk(1'b0, mk_addr(idx, $urandom % 8), tag_word(idx), "R2 random tag read");
            endcase
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule